// File: doc/BRIEF.md
# Ten-Bit Serializer with Loopback Wrap

This block turns a stream of 10-bit words, already carrying a line code, into a serial bit stream running at ten bit-clock cycles per word. Everything runs on one bit clock. An internal slot counter divides that clock into ten-cycle word periods and raises a one-cycle word strobe in the last slot of each period. The host presents the next word while the strobe is high, and the block captures it on the rising edge that closes the strobe cycle.

The captured word is moved into a shift register and sent out least significant bit first. It then passes through a short fixed delay line that stands in for the transmit path latency. A final registered selector either drives the stream onto the external line output, or parks that line at logic 1 and routes the stream to a wrap output. A companion receiver can take the wrap output for loopback testing without any external medium.

Top module: `serializer_wrap`

## Requirements
- R1: During and directly after a synchronous reset, `line_out` and `wrap_out` are 1 and `word_stb` is 0. Every serial slot before the first captured word's bit 0 carries 1.
- R2: Counting rising edges from the first edge with `rst` low as edge 1, `word_stb` is high exactly after edges k with k mod 10 = 9, and low after every other edge.
- R3: `word_in` is sampled only at an edge that ends a cycle in which `word_stb` is high. Values driven in any other cycle never appear in the stream.
- R4: A captured word goes out bit 0 first, then bit 1, up to bit 9, one bit per bit-clock cycle.
- R5: If a word is captured at edge E, its bit n is on the serial output in the cycle following edge E+4+n. This is a fixed latency of 4 bit times (shift load, two delay stages, output register).
- R6: While `loop_en` is 0 at an edge, after that edge `line_out` carries the serial bit and `wrap_out` is 1.
- R7: While `loop_en` is 1 at an edge, after that edge `line_out` is 1 and `wrap_out` carries the serial bit.
- R8: A change of `loop_en` takes effect at the next edge. The bit sequence is not shifted, lost or repeated by the change.
- R9: Words captured in consecutive periods form one gap-free stream: bit 9 of one word is followed directly by bit 0 of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loop_en | input | 1 | 1 = divert stream to `wrap_out` and park `line_out` at 1 |
| word_in | input | 10 | Pre-encoded word to transmit, bit 0 sent first |
| word_stb | output | 1 | High in the last slot of each word period; `word_in` is taken at the edge ending it |
| line_out | output | 1 | External serial output |
| wrap_out | output | 1 | Internal loopback serial output |

## Verification
The strobe is due in the cycle after every edge whose count is 9 mod 10, and the word is sampled at the next edge. Bit n of that word is due four edges plus n after the capture edge. A loopback change is due at the single next edge. The bench counts edges from reset release, drives inputs and samples outputs on falling edges, and records each captured word's bits in an array indexed by the edge after which they are due. Each cycle's outputs are compared against that slot and against the loopback value applied at the same edge.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned SER_WORD_W = 10;
  localparam int unsigned SER_PIPE   = 2;

  typedef enum logic {
    PATH_LINE = 1'b0,
    PATH_WRAP = 1'b1
  } path_e;
endpackage

// File: rtl/ser_slot_ctr.sv
module ser_slot_ctr #(
  parameter int unsigned W = 10
) (
  input  logic clk,
  input  logic rst,
  output logic cap_en,
  output logic load_en,
  output logic word_stb
);
  localparam int unsigned CW   = (W > 1) ? $clog2(W) : 1;
  localparam int unsigned LAST = W - 1;

  logic [CW-1:0] slot_q;
  logic          stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (slot_q == CW'(LAST)) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= (slot_q == CW'(LAST - 1));
    end
  end

  assign cap_en   = (slot_q == CW'(LAST));
  assign load_en  = (slot_q == '0);
  assign word_stb = stb_q;

  // R2: counter wraps to slot 0 after the last slot
  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
    (slot_q == CW'(LAST)) |=> (slot_q == '0));

  // R2: strobe lasts exactly one cycle
  a_r2_stb_single: assert property (@(posedge clk) disable iff (rst)
    stb_q |=> !stb_q);

  // R3: strobe coincides with the capture slot
  a_r3_stb_at_capture: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> (slot_q == CW'(LAST)));
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         load_en,
  input  logic [W-1:0] word_in,
  output logic         bit_out
);
  logic [W-1:0] hold_q;
  logic [W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '1;
    end else if (cap_en) begin
      hold_q <= word_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '1;
    end else if (load_en) begin
      shift_q <= hold_q;
    end else begin
      shift_q <= {1'b1, shift_q[W-1:1]};
    end
  end

  assign bit_out = shift_q[0];

  // R3: the holding register changes only at a capture edge
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(hold_q));

  // R4: the bit leaving next is the one just above the current one
  a_r4_lsb_first: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !cap_en) |=> (shift_q[0] == $past(shift_q[1])));
endmodule

// File: rtl/ser_delay.sv
module ser_delay #(
  parameter int unsigned N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  generate
    if (N == 0) begin : g_none
      assign d_out = d_in;
    end else begin : g_chain
      logic [N-1:0] stage_q;
      for (genvar i = 0; i < N; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            stage_q[i] <= 1'b1;
          end else if (i == 0) begin
            stage_q[i] <= d_in;
          end else begin
            stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
          end
        end
      end
      assign d_out = stage_q[N-1];
    end
  endgenerate
endmodule

// File: rtl/ser_outsel.sv
module ser_outsel
  import ser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic loop_en,
  input  logic bit_in,
  output logic line_out,
  output logic wrap_out
);
  path_e sel;
  logic  line_q;
  logic  wrap_q;

  assign sel = loop_en ? PATH_WRAP : PATH_LINE;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b1;
      wrap_q <= 1'b1;
    end else begin
      case (sel)
        PATH_WRAP: begin
          line_q <= 1'b1;
          wrap_q <= bit_in;
        end
        default: begin
          line_q <= bit_in;
          wrap_q <= 1'b1;
        end
      endcase
    end
  end

  assign line_out = line_q;
  assign wrap_out = wrap_q;

  // R7: loopback parks the external line
  a_r7_line_parked: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> line_out);

  // R6: the wrap path idles high outside loopback
  a_r6_wrap_idle: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> wrap_out);

  // R8: the same bit reaches whichever output is selected
  a_r8_same_bit: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((line_out & wrap_out) == $past(bit_in)));
endmodule

// File: rtl/serializer_wrap.sv
module serializer_wrap
  import ser_pkg::*;
#(
  parameter int unsigned W    = SER_WORD_W,
  parameter int unsigned PIPE = SER_PIPE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loop_en,
  input  logic [W-1:0] word_in,
  output logic         word_stb,
  output logic         line_out,
  output logic         wrap_out
);
  logic cap_en;
  logic load_en;
  logic sh_bit;
  logic dl_bit;

  ser_slot_ctr #(.W(W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .load_en  (load_en),
    .word_stb (word_stb)
  );

  ser_shifter #(.W(W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .load_en (load_en),
    .word_in (word_in),
    .bit_out (sh_bit)
  );

  ser_delay #(.N(PIPE)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .d_in  (sh_bit),
    .d_out (dl_bit)
  );

  ser_outsel u_out (
    .clk      (clk),
    .rst      (rst),
    .loop_en  (loop_en),
    .bit_in   (dl_bit),
    .line_out (line_out),
    .wrap_out (wrap_out)
  );

  // R1: both serial outputs idle high in the cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (line_out && wrap_out && !word_stb));
endmodule

// File: tb/serializer_wrap_test.sv
module serializer_wrap_test;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 10;
  localparam int LAT  = 4;
  localparam int NCYC = 4000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         loop_en = 1'b0;
  logic [W-1:0] word_in = '0;
  logic         word_stb;
  logic         line_out;
  logic         wrap_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit exp_s   [0:NCYC+LAT+W+4];
  bit loop_at [0:NCYC+2];

  serializer_wrap uut (
    .clk      (clk),
    .rst      (rst),
    .loop_en  (loop_en),
    .word_in  (word_in),
    .word_stb (word_stb),
    .line_out (line_out),
    .wrap_out (wrap_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pick_word(input int idx);
    case (idx)
      0: return 10'h3FF;
      1: return 10'h000;
      2: return 10'h001;
      3: return 10'h200;
      4: return 10'h155;
      5: return 10'h2AA;
      6: return 10'h17C;
      7: return 10'h283;
      default: return W'($urandom);
    endcase
  endfunction

  function automatic bit stb_due(input int k);
    return (k % W) == (W - 1);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i <= NCYC+LAT+W+4; i++) exp_s[i] = 1'b1;
    for (int i = 0; i <= NCYC+2; i++) loop_at[i] = 1'b0;
    begin
      int widx;
      widx = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state at the ports
      check(line_out == 1'b1, "R1 line_out in reset", line_out, 1);
      check(wrap_out == 1'b1, "R1 wrap_out in reset", wrap_out, 1);
      check(word_stb == 1'b0, "R1 word_stb in reset", word_stb, 0);
      rst = 1'b0;
      word_in = W'($urandom);
      for (int k = 1; k <= NCYC; k++) begin
        @(posedge clk);
        @(negedge clk);
        // R2: strobe position
        check(word_stb == stb_due(k), "R2 word_stb", word_stb, stb_due(k));
        if (loop_at[k]) begin
          // R7 and R8: line parked, stream on wrap
          check(line_out == 1'b1, "R7 line_out parked", line_out, 1);
          check(wrap_out == exp_s[k], "R7/R4/R5 wrap_out bit", wrap_out, exp_s[k]);
        end else begin
          // R6, R4, R5, R9, R1: stream on line, wrap idle
          check(line_out == exp_s[k], "R6/R4/R5/R9 line_out bit", line_out, exp_s[k]);
          check(wrap_out == 1'b1, "R6 wrap_out idle", wrap_out, 1);
        end
        // drive inputs for edge k+1
        if (stb_due(k)) begin
          logic [W-1:0] w;
          w = pick_word(widx);
          widx++;
          word_in = w;
          for (int n = 0; n < W; n++) exp_s[k+1+LAT+n] = w[n];
        end else begin
          // R3: garbage outside the strobe cycle must never appear
          word_in = W'($urandom);
        end
        if (k < 1500) loop_en = 1'b0;
        else if (k < 2500) loop_en = 1'b1;
        else if (($urandom % 5) == 0) loop_en = ~loop_en;   // R8: random toggles
        loop_at[k+1] = loop_en;
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule